// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial datapath of an SPI master. It divides the system clock to make the serial clock. One shared register then moves a word of 1 to 64 bits in both directions at once: the outgoing bits go out on MOSI, and the incoming MISO bits fill the places they leave. A register front end loads the outgoing word 32 bits at a time and reads the received word back on the same parallel output.

A single start pulse begins a transfer. The character length, bit order, edge choices and divider value are captured at that moment, so the front end may change them while the transfer runs. The drive edge and the sample edge are chosen separately. Because the outgoing and incoming data share the same flip-flops, a word that is not rewritten between two transfers sends the bits it received in the first transfer during the second.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `sclk_o` and `mosi_o` are 0 and `rx_word_o` is all zeros.
- R2: While busy, `sclk_o` toggles once every (`div_i`+1) system clocks, so its period is 2×(`div_i`+1) clocks. The first edge is a rising edge, (`div_i`+1) clocks after the start is taken. `sclk_o` stays low while not busy.
- R3: A transfer of n bits makes 2n serial clock edges and keeps `busy_o` high for exactly 2n×(`div_i`+1) clocks. `done_o` is high for one clock, in the first cycle after `busy_o` falls. A `char_len_i` of 0, or any value above 64, means n = 64.
- R4: With `lsb_first_i` = 0, bit n-1 is sent first and bit 0 last. The k-th received bit (counting from 0) is stored at position n-1-k.
- R5: With `lsb_first_i` = 1, bit 0 is sent first. The k-th received bit is stored at position k.
- R6: From the cycle after the start is taken, `mosi_o` shows the first bit. It moves to the next bit only on a drive edge that comes after the current bit has been sampled. The drive edge is the falling edge when `drv_fall_i` = 1 and the rising edge otherwise. `mosi_o` does not change while idle.
- R7: MISO is sampled on the falling edge when `smp_fall_i` = 1 and on the rising edge otherwise. This holds for every one of the four combinations with `drv_fall_i`, including both flags on the same edge.
- R8: `rx_word_o` shows the shared register. After a transfer it holds the received bits in positions 0..n-1 and the old contents above n-1. Starting again without a write sends those received bits out.
- R9: Setting `wr_en_i` while idle replaces bits [32×`wr_idx_i`+31 : 32×`wr_idx_i`] with `wr_data_i` on the next clock. The write is ignored while busy, when `start_i` is high in the same cycle, and when `wr_idx_i` is 2 or 3.
- R10: A start while busy is ignored. Changes to the length, order, edge or divider inputs during a transfer have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; taken only while idle |
| char_len_i | input | 7 | Bits per transfer; 0 or more than 64 selects 64 |
| lsb_first_i | input | 1 | 1: bit 0 first; 0: top bit of the character first |
| drv_fall_i | input | 1 | 1: MOSI changes on the falling SCLK edge |
| smp_fall_i | input | 1 | 1: MISO is sampled on the falling SCLK edge |
| div_i | input | 16 | Divider; each SCLK half period lasts div_i+1 clocks |
| wr_en_i | input | 1 | Parallel write strobe for one 32-bit lane |
| wr_idx_i | input | 2 | Lane index of the write |
| wr_data_i | input | 32 | Lane data |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to the slave |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| rx_word_o | output | 64 | Shared transmit/receive register |

## Verification
The assertions check on every cycle that the serial clock is quiet while idle and that every edge during a transfer keeps the spacing set by the divider captured at start. They also check that the end pulse is one cycle long and comes exactly when busy falls, and that the word and MOSI hold still while idle with no start or write. The bench's scenarios are needed for the rest: the bit order, where each received bit lands, the four drive/sample edge pairings, retransmission of the received word, the length rules, and the inputs that must be ignored. Its cycle-level model checks all of these against the outputs on every clock.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

   // Transfer options captured when a start is accepted
   typedef struct packed {
      logic lsb_first;
      logic drv_fall;
      logic smp_fall;
   } xfer_mode_t;

   // True when the coming SCLK edge is the one selected by on_fall
   function automatic logic edge_hit(input logic rising, input logic on_fall);
      return rising ^ on_fall;
   endfunction

endpackage

// File: rtl/spi_eng_clkdiv.sv
module spi_eng_clkdiv #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o,
   output logic             rising_o,
   output logic             sclk_o
);

   logic [DIV_W-1:0] cnt_q;
   logic             sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (!run_i) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (cnt_q == div_i) begin
         cnt_q  <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         cnt_q  <= cnt_q + DIV_W'(1);
      end
   end

   assign tick_o   = run_i && (cnt_q == div_i);
   assign rising_o = ~sclk_q;
   assign sclk_o   = sclk_q;

endmodule

// File: rtl/spi_eng_shreg.sv
module spi_eng_shreg #(
   parameter int MAX_BITS = 64,
   parameter int LANE_W   = 32,
   parameter int IDX_W    = 2,
   localparam int CNT_W   = $clog2(MAX_BITS + 1),
   localparam int PTR_W   = $clog2(MAX_BITS),
   localparam int NLANES  = MAX_BITS / LANE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [CNT_W-1:0]    n_now_i,
   input  logic                lsb_now_i,
   input  logic [CNT_W-1:0]    n_run_i,
   input  logic                lsb_run_i,
   input  logic                smp_i,
   input  logic                drv_i,
   input  logic                miso_i,
   input  logic                wr_i,
   input  logic [IDX_W-1:0]    wr_idx_i,
   input  logic [LANE_W-1:0]   wr_data_i,
   output logic [MAX_BITS-1:0] word_o,
   output logic                mosi_o
);

   logic [MAX_BITS-1:0] sreg;
   logic [CNT_W-1:0]    tx_q, rx_q, tx_nx;
   logic                mosi_q;
   logic [NLANES-1:0]   lane_hit;

   // Position of the k-th bit on the line within an n-bit character
   function automatic logic [PTR_W-1:0] slot(input logic [CNT_W-1:0] k,
                                             input logic [CNT_W-1:0] n,
                                             input logic lsb);
      logic [CNT_W-1:0] p;
      p = lsb ? k : (n - k - CNT_W'(1));
      return p[PTR_W-1:0];
   endfunction

   for (genvar g = 0; g < NLANES; g++) begin : g_lane
      assign lane_hit[g] = wr_i && (wr_idx_i == IDX_W'(g));
   end

   assign tx_nx = tx_q + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg   <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
         mosi_q <= 1'b0;
      end else if (load_i) begin
         tx_q   <= '0;
         rx_q   <= '0;
         mosi_q <= sreg[slot('0, n_now_i, lsb_now_i)];
      end else if (wr_i) begin
         for (int l = 0; l < NLANES; l++) begin
            if (lane_hit[l]) sreg[l*LANE_W +: LANE_W] <= wr_data_i;
         end
      end else begin
         if (smp_i) begin
            sreg[slot(rx_q, n_run_i, lsb_run_i)] <= miso_i;
            rx_q <= rx_q + CNT_W'(1);
         end
         if (drv_i && (tx_q < rx_q)) begin
            tx_q <= tx_nx;
            if (tx_nx < n_run_i) mosi_q <= sreg[slot(tx_nx, n_run_i, lsb_run_i)];
         end
      end
   end

   assign word_o = sreg;
   assign mosi_o = mosi_q;

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
   parameter int MAX_BITS = 64,
   parameter int LANE_W   = 32,
   parameter int IDX_W    = 2,
   parameter int LEN_W    = 7,
   parameter int DIV_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [LEN_W-1:0]    char_len_i,
   input  logic                lsb_first_i,
   input  logic                drv_fall_i,
   input  logic                smp_fall_i,
   input  logic [DIV_W-1:0]    div_i,
   input  logic                wr_en_i,
   input  logic [IDX_W-1:0]    wr_idx_i,
   input  logic [LANE_W-1:0]   wr_data_i,
   input  logic                miso_i,
   output logic                sclk_o,
   output logic                mosi_o,
   output logic                busy_o,
   output logic                done_o,
   output logic [MAX_BITS-1:0] rx_word_o
);
   import spi_eng_pkg::*;

   localparam int CNT_W  = $clog2(MAX_BITS + 1);
   localparam int NLANES = MAX_BITS / LANE_W;
   localparam int EDG_W  = CNT_W + 1;

   if (MAX_BITS % LANE_W != 0) begin : g_bad_lanes
      $error("word width must be a whole number of lanes");
   end
   if (NLANES > (1 << IDX_W)) begin : g_bad_index
      $error("lane index too narrow for the word");
   end
   if ((1 << LEN_W) < MAX_BITS) begin : g_bad_len
      $error("length field cannot express the word width");
   end

   logic             busy_q, done_q;
   logic [CNT_W-1:0] n_q, n_now;
   logic [DIV_W-1:0] div_q;
   xfer_mode_t       mode_q;
   logic [EDG_W-1:0] edge_q, last_idx;
   logic             tick, rising, start_ok, wr_ok, drv_stb, smp_stb, fin;

   always_comb begin
      if (char_len_i == '0 || int'(char_len_i) > MAX_BITS) n_now = CNT_W'(MAX_BITS);
      else                                                n_now = CNT_W'(char_len_i);
   end

   assign start_ok = start_i & ~busy_q;
   assign wr_ok    = wr_en_i & ~busy_q & ~start_i;
   assign last_idx = {n_q, 1'b0} - EDG_W'(1);
   assign fin      = tick && (edge_q == last_idx);
   assign drv_stb  = tick & edge_hit(rising, mode_q.drv_fall);
   assign smp_stb  = tick & edge_hit(rising, mode_q.smp_fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         edge_q <= '0;
         n_q    <= '0;
         div_q  <= '0;
         mode_q <= '0;
      end else begin
         done_q <= fin;
         if (start_ok) begin
            busy_q <= 1'b1;
            edge_q <= '0;
            n_q    <= n_now;
            div_q  <= div_i;
            mode_q <= '{lsb_first: lsb_first_i, drv_fall: drv_fall_i, smp_fall: smp_fall_i};
         end else if (fin) begin
            busy_q <= 1'b0;
         end else if (tick) begin
            edge_q <= edge_q + EDG_W'(1);
         end
      end
   end

   spi_eng_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (busy_q),
      .div_i   (div_q),
      .tick_o  (tick),
      .rising_o(rising),
      .sclk_o  (sclk_o)
   );

   spi_eng_shreg #(.MAX_BITS(MAX_BITS), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_sr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (start_ok),
      .n_now_i  (n_now),
      .lsb_now_i(lsb_first_i),
      .n_run_i  (n_q),
      .lsb_run_i(mode_q.lsb_first),
      .smp_i    (smp_stb),
      .drv_i    (drv_stb),
      .miso_i   (miso_i),
      .wr_i     (wr_ok),
      .wr_idx_i (wr_idx_i),
      .wr_data_i(wr_data_i),
      .word_o   (rx_word_o),
      .mosi_o   (mosi_o)
   );

   assign busy_o = busy_q;
   assign done_o = done_q;

endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk #(
   parameter int DIV_W    = 16,
   parameter int MAX_BITS = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic                wr_en_i,
   input logic [DIV_W-1:0]    div_i,
   input logic                busy_o,
   input logic                done_o,
   input logic                sclk_o,
   input logic                mosi_o,
   input logic [MAX_BITS-1:0] rx_word_o
);

   logic             sclk_d;
   logic [DIV_W:0]   gap;
   logic [DIV_W-1:0] div_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         gap     <= '0;
         div_cap <= '0;
      end else begin
         sclk_d <= sclk_o;
         if (start_i && !busy_o) begin
            gap     <= '0;
            div_cap <= div_i;
         end else if (busy_o) begin
            gap <= (sclk_o != sclk_d) ? (DIV_W+1)'(1) : gap + (DIV_W+1)'(1);
         end
      end
   end

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> !sclk_o); // R2
   AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && (sclk_o != sclk_d)) |-> (gap == {1'b0, div_cap} + (DIV_W+1)'(1))); // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R3
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_o) |-> done_o); // R3
   AST_DONE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> $fell(busy_o)); // R3
   AST_WORD_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $past(!busy_o && !start_i && !wr_en_i) |-> $stable(rx_word_o)); // R9
   AST_MOSI_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $past(!busy_o && !start_i) |-> $stable(mosi_o)); // R6

endmodule

bind spi_shift_engine spi_shift_engine_chk #(.DIV_W(DIV_W), .MAX_BITS(MAX_BITS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .wr_en_i  (wr_en_i),
   .div_i    (div_i),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .sclk_o   (sclk_o),
   .mosi_o   (mosi_o),
   .rx_word_o(rx_word_o)
);

// File: tb/spi_shift_engine_tb.sv
`timescale 1ns/1ps
module spi_shift_engine_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [6:0]  char_len_i = '0;
   logic        lsb_first_i = 1'b0, drv_fall_i = 1'b0, smp_fall_i = 1'b0;
   logic [15:0] div_i = '0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  wr_idx_i = '0;
   logic [31:0] wr_data_i = '0;
   logic        miso_i = 1'b0;
   logic        sclk_o, mosi_o, busy_o, done_o;
   logic [63:0] rx_word_o;

   always #2.5 clk = ~clk;

   spi_shift_engine u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .char_len_i(char_len_i),
      .lsb_first_i(lsb_first_i), .drv_fall_i(drv_fall_i), .smp_fall_i(smp_fall_i),
      .div_i(div_i), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
      .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o), .busy_o(busy_o),
      .done_o(done_o), .rx_word_o(rx_word_o)
   );

   int    n_cmp = 0, n_bad = 0, cyc = 0;
   string tag = "R1";

   // Behavioural reference
   logic [63:0] m_word = '0, m_orig = '0, sl_bits = '0;
   logic        m_busy = 0, m_done = 0, m_sclk = 0, m_mosi = 0;
   logic        m_lsb = 0, m_txf = 0, m_rxf = 0;
   int          m_t = 0, m_n = 1, m_d = 0, m_tx = 0, m_rx = 0;

   function automatic int slot(int k, int n, logic lsb);
      return lsb ? k : n - 1 - k;
   endfunction

   always @(posedge clk) begin : model
      int   k, otx, orx;
      logic rising, smp, drv;
      if (!rst_n) begin
         m_word = '0; m_busy = 0; m_done = 0; m_sclk = 0; m_mosi = 0;
      end else if (m_busy) begin
         m_done = 0;
         m_t++;
         if (m_t % (m_d + 1) == 0) begin
            k      = m_t / (m_d + 1);
            rising = (k % 2) == 1;
            smp    = m_rxf ? !rising : rising;
            drv    = m_txf ? !rising : rising;
            otx    = m_tx;
            orx    = m_rx;
            if (smp) begin
               m_word[slot(orx, m_n, m_lsb)] = miso_i;
               m_rx++;
            end
            if (drv && otx < orx) begin
               m_tx++;
               if (m_tx < m_n) m_mosi = m_orig[slot(m_tx, m_n, m_lsb)];
            end
            m_sclk = rising;
            if (k == 2 * m_n) begin
               m_busy = 0;
               m_done = 1;
            end
         end
      end else begin
         m_done = 0;
         if (start_i) begin
            m_n    = (char_len_i == 0 || char_len_i > 64) ? 64 : int'(char_len_i);
            m_d    = int'(div_i);
            m_lsb  = lsb_first_i;
            m_txf  = drv_fall_i;
            m_rxf  = smp_fall_i;
            m_orig = m_word;
            m_mosi = m_word[slot(0, m_n, m_lsb)];
            m_busy = 1;
            m_t = 0; m_tx = 0; m_rx = 0;
         end else if (wr_en_i && wr_idx_i < 2) begin
            m_word[int'(wr_idx_i) * 32 +: 32] = wr_data_i;
         end
      end
   end

   // Slave: presents the bit the master will sample next
   always @(negedge clk) miso_i = sl_bits[(m_rx < 64) ? m_rx : 0];

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2", 64'(sclk_o), 64'(m_sclk), "sclk");
         chk("R3", 64'(busy_o), 64'(m_busy), "busy");
         chk("R3", 64'(done_o), 64'(m_done), "done");
         chk({"R6/", tag}, 64'(mosi_o), 64'(m_mosi), "mosi");
         chk({"R8/", tag}, rx_word_o, m_word, "word");
      end
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_bad++;
         $display("FAIL R3 watchdog: actual still running, expected finished");
         summary();
         $finish;
      end
   end

   task automatic wr(input logic [1:0] idx, input logic [31:0] data);
      @(negedge clk);
      wr_en_i = 1; wr_idx_i = idx; wr_data_i = data;
      @(negedge clk);
      wr_en_i = 0;
   endtask

   task automatic go(input string t, input int len, input logic lsb, input logic txf,
                     input logic rxf, input int div, input logic [63:0] slave,
                     input bit poke, input bit wr_same);
      int n, cnt;
      tag = t;
      n = (len == 0 || len > 64) ? 64 : len;
      @(negedge clk);
      sl_bits = slave;
      char_len_i = 7'(len); lsb_first_i = lsb; drv_fall_i = txf; smp_fall_i = rxf;
      div_i = 16'(div); start_i = 1;
      if (wr_same) begin wr_en_i = 1; wr_idx_i = 2'd1; wr_data_i = 32'h0; end
      @(negedge clk);
      start_i = 0; wr_en_i = 0;
      cnt = 0;
      while (busy_o && cnt < 20000) begin
         if (poke && cnt == 3) begin
            start_i = 1; wr_en_i = 1; wr_idx_i = 0; wr_data_i = 32'hFFFF_FFFF;
            div_i = 16'd7; char_len_i = 7'd3; lsb_first_i = ~lsb;
         end
         if (poke && cnt == 4) begin start_i = 0; wr_en_i = 0; end
         cnt++;
         @(negedge clk);
      end
      chk("R3", 64'(cnt), 64'(2 * n * (div + 1)), {"busy length ", t});
      @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1", 64'(busy_o), 64'd0, "busy after reset");
      chk("R1", 64'(done_o), 64'd0, "done after reset");
      chk("R1", 64'(sclk_o), 64'd0, "sclk after reset");
      chk("R1", 64'(mosi_o), 64'd0, "mosi after reset");
      chk("R1", rx_word_o, 64'd0, "word after reset");

      wr(2'd0, 32'hA5C3_0F96);
      wr(2'd1, 32'h1234_5678);
      wr(2'd2, 32'hDEAD_BEEF);
      @(negedge clk);
      chk("R9", rx_word_o, 64'h1234_5678_A5C3_0F96, "lane write and out-of-range index");

      go("R4", 8, 0, 1, 0, 1, 64'h0000_0000_0000_00B4, 0, 0);
      chk("R4", rx_word_o, 64'h1234_5678_A5C3_0F2D, "msb-first received byte");
      go("R5", 13, 1, 0, 1, 0, 64'h0000_0000_0000_1ACE, 0, 0);
      go("R8", 8, 0, 1, 0, 2, 64'h0000_0000_0000_0055, 0, 0);
      go("R10", 0, 1, 1, 0, 0, 64'hC0FF_EE00_1357_9BDF, 1, 0);
      chk("R10", rx_word_o, 64'hC0FF_EE00_1357_9BDF, "64-bit lsb-first word despite pokes");
      go("R7", 5, 0, 0, 0, 2, 64'h0000_0000_0000_0013, 0, 0);
      go("R7", 6, 1, 1, 1, 1, 64'h0000_0000_0000_002A, 0, 0);
      go("R9", 9, 0, 1, 0, 0, 64'h0000_0000_0000_01F0, 0, 1);
      chk("R9", rx_word_o[63:32], 64'hC0FF_EE00, "write with start ignored");
      go("R3", 100, 0, 1, 0, 0, 64'h8000_0000_0000_0001, 0, 0);
      chk("R3", rx_word_o, 64'h8000_0000_0000_0001, "over-long length means 64 bits");

      summary();
      $finish;
   end

endmodule